// File: doc/BRIEF.md
# Serial Register-Bank Target

This block is a two-wire serial bus target (I2C-compatible, 7-bit addressing) that lets a host controller read and write a bank of configuration registers inside the chip. The bus lines are oversampled by a fast system clock through synchronisers. The target drives the data line only by asserting an open-drain enable. One input pin selects between two bus addresses, so two copies can share one bus.

The bank spans pointer values 0x00 to 0x12. Entries 0x00 to 0x0F are writable configuration registers. They reset to fixed defaults and are presented in parallel on one flat output vector. Entries 0x10, 0x11 and 0x12 are read-only views of status inputs. Bit 7 of 0x11 is a sticky power-on indicator. A host first writes a pointer byte. It then either streams data bytes into successive entries, or issues a repeated START and streams entries back out. The pointer advances after every byte in both directions.

Top module: `i2c_regbank_slave`

## Requirements
- R1: The target answers the 7-bit address 1100_0A0 (binary, MSB first), where A is `addr_sel_i`. The address byte is therefore 0xC0 (write) or 0xC1 (read) with the pin low, and 0xC4 or 0xC5 with the pin high. For any other address it leaves SDA released, ignores every following byte, and waits for the next START.
- R2: A START (SDA falling while SCL is high) begins a new address phase at any point. A STOP (SDA rising while SCL is high) releases SDA and abandons any partly received byte without writing it.
- R3: Bytes travel MSB first, with one bit per SCL cycle. After a matching address byte and after every byte received in a write, the target holds SDA low across the ninth SCL high phase. It changes its SDA drive only while SCL is low.
- R4: In a write, the first byte after the address loads the register pointer. Each following byte is stored at the pointer, appears on `ctrl_o[8*k+7:8*k]` for entry k, and then advances the pointer by one.
- R5: After a repeated START with the read address, the target returns the entry at the pointer and advances the pointer. It keeps returning successive entries while the host ACKs. After a host NACK it releases SDA and sends nothing more.
- R6: Bytes written while the pointer is 0x10, 0x11 or 0x12 change no register, and the pointer still advances.
- R7: The pointer steps from 0x12 to 0x00 in both reads and writes. A pointer byte above 0x12 selects 0x00.
- R8: After reset the writable entries hold 0x00=0x17, 0x01=0x18, 0x04=0xDB, 0x05=0x7C, 0x06=0x0A, 0x07=0x08, 0x09=0xC0, 0x0A=0x87, 0x0B=0x40, and 0x00 everywhere else. SDA is released after reset.
- R9: Bit 7 of entry 0x11 reads 1 after reset. It clears when entry 0x0C is sent in a read, and stays 0 until the next reset, including across writes to 0x11.
- R10: Entry 0x10 returns `stat_tf_i`, bits 6:0 of 0x11 return `stat_chip_i`, and entry 0x12 returns `stat_tune_i`, each sampled when the byte is loaded for sending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, many times faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| addr_sel_i | input | 1 | Selects bit 1 of the 7-bit bus address |
| stat_tf_i | input | 8 | Status returned at entry 0x10 |
| stat_chip_i | input | 7 | Status returned in bits 6:0 of entry 0x11 |
| stat_tune_i | input | 8 | Status returned at entry 0x12 |
| sda_oe_o | output | 1 | Open-drain enable: 1 pulls SDA low |
| ctrl_o | output | 128 | The sixteen writable entries, entry k in bits 8k+7:8k |

## Verification
A wrong bit counter or state shows at the ports within one byte. Either the ACK slot reads high, or the returned byte is shifted by one position. A pointer fault appears as a misplaced value on `ctrl_o` after the very next write, or as the wrong entry in the next read. The wrap and read-only cases are only visible when a burst crosses 0x10 or 0x12, so the bench aims bursts there. A power-on flag that never clears, or that clears early, shows in the next read of 0x11, which the bench makes both before and after reading 0x0C.

// File: rtl/i2c_rb_pkg.sv
package i2c_rb_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK
  } link_state_t;

  // reset values of the writable bank
  function automatic logic [7:0] ctrl_default(input int idx);
    case (idx)
      0:  return 8'h17;
      1:  return 8'h18;
      4:  return 8'hDB;
      5:  return 8'h7C;
      6:  return 8'h0A;
      7:  return 8'h08;
      9:  return 8'hC0;
      10: return 8'h87;
      11: return 8'h40;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/i2c_rb_sync.sv
module i2c_rb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_q,
  output logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [1:0] raw;
  logic [1:0] synced;

  assign raw = {sda_in, scl_in};

  // one synchroniser chain per bus line, idle level high
  for (genvar g = 0; g < 2; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '1;
      else     chain <= {chain[STAGES-2:0], raw[g]};
    end
    assign synced[g] = chain[STAGES-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q     <= 1'b1;
      sda_q     <= 1'b1;
      scl_rise  <= 1'b0;
      scl_fall  <= 1'b0;
      start_det <= 1'b0;
      stop_det  <= 1'b0;
    end else begin
      scl_q     <= synced[0];
      sda_q     <= synced[1];
      scl_rise  <= synced[0] & ~scl_q;
      scl_fall  <= ~synced[0] & scl_q;
      start_det <= synced[0] & scl_q & sda_q & ~synced[1];
      stop_det  <= synced[0] & scl_q & ~sda_q & synced[1];
    end
  end

endmodule

// File: rtl/i2c_rb_link.sv
module i2c_rb_link
  import i2c_rb_pkg::*;
#(
  parameter logic [6:0] ADDR_BASE    = 7'b1100000,
  parameter int         ADDR_PIN_BIT = 1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        addr_pin,
  input  logic        scl_q,
  input  logic        sda_q,
  input  logic        scl_rise,
  input  logic        scl_fall,
  input  logic        start_det,
  input  logic        stop_det,
  input  logic [7:0]  rd_data,
  output logic [7:0]  byte_q,
  output logic        ptr_load,
  output logic        wr_strobe,
  output logic        rd_take,
  output logic        sda_oe
);

  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  link_state_t      st;
  logic [CNT_W-1:0] bit_cnt;
  logic             byte_full;
  logic [7:0]       sh;
  logic             first_rx;
  logic             rw_bit;
  logic             host_ack;
  logic [6:0]       my_addr;

  assign my_addr = ADDR_BASE | (7'(addr_pin) << ADDR_PIN_BIT);
  assign byte_q  = sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      bit_cnt   <= '0;
      byte_full <= 1'b0;
      sh        <= '0;
      first_rx  <= 1'b0;
      rw_bit    <= 1'b0;
      host_ack  <= 1'b0;
      sda_oe    <= 1'b0;
      ptr_load  <= 1'b0;
      wr_strobe <= 1'b0;
      rd_take   <= 1'b0;
    end else begin
      ptr_load  <= 1'b0;
      wr_strobe <= 1'b0;
      rd_take   <= 1'b0;
      if (start_det) begin
        st        <= ST_ADDR;
        bit_cnt   <= '0;
        byte_full <= 1'b0;
        sda_oe    <= 1'b0;
      end else if (stop_det) begin
        st        <= ST_IDLE;
        bit_cnt   <= '0;
        byte_full <= 1'b0;
        sda_oe    <= 1'b0;
      end else begin
        case (st)
          ST_ADDR, ST_RX: begin
            if (scl_rise && !byte_full) begin
              sh      <= {sh[6:0], sda_q};
              bit_cnt <= bit_cnt + 1'b1;
              if (bit_cnt == LAST_BIT) byte_full <= 1'b1;
            end else if (scl_fall && byte_full) begin
              byte_full <= 1'b0;
              bit_cnt   <= '0;
              if (st == ST_ADDR) begin
                if (sh[7:1] == my_addr) begin
                  st     <= ST_ADDR_ACK;
                  sda_oe <= 1'b1;
                  rw_bit <= sh[0];
                end else begin
                  st <= ST_IDLE;
                end
              end else begin
                st       <= ST_RX_ACK;
                sda_oe   <= 1'b1;
                first_rx <= 1'b0;
                if (first_rx) ptr_load  <= 1'b1;
                else          wr_strobe <= 1'b1;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              if (rw_bit) begin
                st      <= ST_TX;
                sh      <= rd_data;
                rd_take <= 1'b1;
                sda_oe  <= ~rd_data[7];
              end else begin
                st       <= ST_RX;
                first_rx <= 1'b1;
                sda_oe   <= 1'b0;
              end
            end
          end
          ST_RX_ACK: begin
            if (scl_fall) begin
              st     <= ST_RX;
              sda_oe <= 1'b0;
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              bit_cnt <= bit_cnt + 1'b1;
              if (bit_cnt == LAST_BIT) byte_full <= 1'b1;
            end else if (scl_fall) begin
              if (byte_full) begin
                byte_full <= 1'b0;
                bit_cnt   <= '0;
                st        <= ST_TX_ACK;
                sda_oe    <= 1'b0;
              end else begin
                sh     <= {sh[6:0], 1'b0};
                sda_oe <= ~sh[6];
              end
            end
          end
          ST_TX_ACK: begin
            if (scl_rise) begin
              host_ack <= ~sda_q;
            end else if (scl_fall) begin
              if (host_ack) begin
                st      <= ST_TX;
                sh      <= rd_data;
                rd_take <= 1'b1;
                sda_oe  <= ~rd_data[7];
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_DRIVE_ON_LOW: assert property (@(posedge clk) disable iff (rst) $rose(sda_oe) |-> !scl_q); // R3
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst) (st == ST_IDLE) |-> !sda_oe); // R1
  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (rst) stop_det |=> !sda_oe); // R2
  AST_FOREIGN_NOACK: assert property (@(posedge clk) disable iff (rst) (st == ST_ADDR && scl_fall && byte_full && sh[7:1] != my_addr) |=> !sda_oe); // R1

endmodule

// File: rtl/i2c_rb_regs.sv
module i2c_rb_regs
  import i2c_rb_pkg::*;
#(
  parameter int NUM_RW       = 16,
  parameter int POR_CLR_ADDR = 12
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ptr_load,
  input  logic                  wr_strobe,
  input  logic                  rd_take,
  input  logic [7:0]            byte_in,
  input  logic [7:0]            stat_a,
  input  logic [6:0]            stat_b,
  input  logic [7:0]            stat_c,
  output logic [7:0]            rd_data,
  output logic [NUM_RW*8-1:0]   ctrl_flat
);

  localparam int NUM_RO   = 3;
  localparam int NUM_ADDR = NUM_RW + NUM_RO;
  localparam int PTR_W    = $clog2(NUM_ADDR);
  localparam int IDX_W    = $clog2(NUM_RW);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(NUM_ADDR - 1);
  localparam logic [PTR_W-1:0] RO_BASE  = PTR_W'(NUM_RW);
  localparam logic [PTR_W-1:0] FLAG_PTR = PTR_W'(NUM_RW + 1);
  localparam logic [PTR_W-1:0] CLR_PTR  = PTR_W'(POR_CLR_ADDR);

  logic [7:0]       bank [NUM_RW];
  logic [PTR_W-1:0] ptr;
  logic             por_flag;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  // reset defaults keep this bank in flops rather than RAM
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_RW; i++) bank[i] <= ctrl_default(i);
    end else if (wr_strobe && ptr < RO_BASE) begin
      bank[ptr[IDX_W-1:0]] <= byte_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr      <= '0;
      por_flag <= 1'b1;
    end else begin
      if (ptr_load)
        ptr <= (byte_in > 8'(NUM_ADDR - 1)) ? '0 : byte_in[PTR_W-1:0];
      else if (wr_strobe || rd_take)
        ptr <= step(ptr);
      if (rd_take && ptr == CLR_PTR) por_flag <= 1'b0;
    end
  end

  always_comb begin
    if (ptr < RO_BASE)        rd_data = bank[ptr[IDX_W-1:0]];
    else if (ptr == RO_BASE)  rd_data = stat_a;
    else if (ptr == FLAG_PTR) rd_data = {por_flag, stat_b};
    else                      rd_data = stat_c;
  end

  for (genvar k = 0; k < NUM_RW; k++) begin : g_out
    assign ctrl_flat[k*8 +: 8] = bank[k];
  end

  AST_PTR_IN_RANGE: assert property (@(posedge clk) disable iff (rst) ptr <= LAST_PTR); // R7
  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (rst) (wr_strobe && ptr == LAST_PTR) |=> ptr == '0); // R7
  AST_RO_IGNORED: assert property (@(posedge clk) disable iff (rst) (wr_strobe && ptr >= RO_BASE) |=> $stable(ctrl_flat)); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst) !por_flag |=> !por_flag); // R9

endmodule

// File: rtl/i2c_regbank_slave.sv
module i2c_regbank_slave #(
  parameter int         SYNC_STAGES  = 2,
  parameter int         NUM_RW       = 16,
  parameter int         POR_CLR_ADDR = 12,
  parameter logic [6:0] ADDR_BASE    = 7'b1100000,
  parameter int         ADDR_PIN_BIT = 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                scl_i,
  input  logic                sda_i,
  input  logic                addr_sel_i,
  input  logic [7:0]          stat_tf_i,
  input  logic [6:0]          stat_chip_i,
  input  logic [7:0]          stat_tune_i,
  output logic                sda_oe_o,
  output logic [NUM_RW*8-1:0] ctrl_o
);

  logic scl_q, sda_q, scl_rise, scl_fall, start_det, stop_det;
  logic [7:0] rd_data, byte_q;
  logic ptr_load, wr_strobe, rd_take;

  i2c_rb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_in(scl_i), .sda_in(sda_i),
    .scl_q(scl_q), .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_rb_link #(.ADDR_BASE(ADDR_BASE), .ADDR_PIN_BIT(ADDR_PIN_BIT)) u_link (
    .clk(clk), .rst(rst), .addr_pin(addr_sel_i),
    .scl_q(scl_q), .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .rd_data(rd_data),
    .byte_q(byte_q), .ptr_load(ptr_load), .wr_strobe(wr_strobe),
    .rd_take(rd_take), .sda_oe(sda_oe_o)
  );

  i2c_rb_regs #(.NUM_RW(NUM_RW), .POR_CLR_ADDR(POR_CLR_ADDR)) u_regs (
    .clk(clk), .rst(rst), .ptr_load(ptr_load), .wr_strobe(wr_strobe),
    .rd_take(rd_take), .byte_in(byte_q), .stat_a(stat_tf_i),
    .stat_b(stat_chip_i), .stat_c(stat_tune_i), .rd_data(rd_data),
    .ctrl_flat(ctrl_o)
  );

endmodule

// File: tb/i2c_regbank_slave_tb.sv
module i2c_regbank_slave_tb;

  localparam int Q = 8;
  localparam int WATCHDOG = 180000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic addr_sel = 1'b0;
  logic [7:0] st_tf = 8'h00;
  logic [6:0] st_chip = 7'h00;
  logic [7:0] st_tune = 8'h00;
  logic sda_oe;
  logic [127:0] ctrl;
  logic sda_bus;

  assign sda_bus = m_sda & ~sda_oe;

  always #5 clk = ~clk;

  i2c_regbank_slave u_dut (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_bus), .addr_sel_i(addr_sel),
    .stat_tf_i(st_tf), .stat_chip_i(st_chip), .stat_tune_i(st_tune),
    .sda_oe_o(sda_oe), .ctrl_o(ctrl)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  logic [7:0] exp_mem [16];
  logic exp_por;
  int exp_ptr;
  logic [7:0] dbuf [8];

  function automatic logic [7:0] dflt(input int a);
    case (a)
      0: return 8'h17;  1: return 8'h18;  4: return 8'hDB;  5: return 8'h7C;
      6: return 8'h0A;  7: return 8'h08;  9: return 8'hC0; 10: return 8'h87;
      11: return 8'h40;
      default: return 8'h00;
    endcase
  endfunction

  function automatic int nxt(input int p);
    return (p == 18) ? 0 : p + 1;
  endfunction

  function automatic logic [7:0] exp_val(input int a);
    if (a < 16) return exp_mem[a];
    if (a == 16) return st_tf;
    if (a == 17) return {exp_por, st_chip};
    return st_tune;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_ctrl(input string tag);
    for (int i = 0; i < 16; i++) check(tag, 32'(ctrl[i*8 +: 8]), 32'(exp_mem[i]));
  endtask

  task automatic wq(input int n = 1);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic bus_start;
    m_sda = 1'b1; m_scl = 1'b1; wq(); m_sda = 1'b0; wq(); m_scl = 1'b0; wq();
  endtask

  task automatic bus_rstart;
    m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); m_sda = 1'b0; wq(); m_scl = 1'b0; wq();
  endtask

  task automatic bus_stop;
    m_sda = 1'b0; wq(); m_scl = 1'b1; wq(); m_sda = 1'b1; wq();
  endtask

  task automatic put_bits(input logic [7:0] b, input int nb);
    for (int i = 7; i > 7 - nb; i--) begin
      m_sda = b[i]; wq(); m_scl = 1'b1; wq(2); m_scl = 1'b0; wq();
    end
  endtask

  task automatic put_byte(input logic [7:0] b, output logic acked);
    put_bits(b, 8);
    m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); acked = ~sda_bus; wq(); m_scl = 1'b0; wq();
  endtask

  task automatic get_byte(input logic give_ack, output logic [7:0] b);
    b = 8'h00;
    m_sda = 1'b1;
    for (int i = 0; i < 8; i++) begin
      wq(); m_scl = 1'b1; wq(); b = {b[6:0], sda_bus}; wq(); m_scl = 1'b0; wq();
    end
    m_sda = give_ack ? 1'b0 : 1'b1;
    wq(); m_scl = 1'b1; wq(2); m_scl = 1'b0; wq(); m_sda = 1'b1;
  endtask

  function automatic logic [7:0] dev(input logic rd);
    return {5'b11000, addr_sel, 1'b0, rd};
  endfunction

  task automatic do_write(input int p, input int n);
    logic a;
    bus_start;
    put_byte(dev(1'b0), a); check("R1 address ack", 32'(a), 1);
    put_byte(8'(p), a);     check("R3 pointer ack", 32'(a), 1);
    exp_ptr = (p > 18) ? 0 : p;
    for (int k = 0; k < n; k++) begin
      put_byte(dbuf[k], a); check("R3 data ack", 32'(a), 1);
      if (exp_ptr < 16) exp_mem[exp_ptr] = dbuf[k];
      exp_ptr = nxt(exp_ptr);
    end
    bus_stop;
    wq();
  endtask

  task automatic do_read(input int p, input int n);
    logic a;
    logic [7:0] got;
    logic [7:0] want;
    bus_start;
    put_byte(dev(1'b0), a); check("R1 address ack", 32'(a), 1);
    put_byte(8'(p), a);     check("R3 pointer ack", 32'(a), 1);
    exp_ptr = (p > 18) ? 0 : p;
    bus_rstart;
    put_byte(dev(1'b1), a); check("R5 read address ack", 32'(a), 1);
    for (int k = 0; k < n; k++) begin
      want = exp_val(exp_ptr);
      get_byte(k < n - 1, got);
      if (exp_ptr == 17)      check("R9 R10 flag entry", 32'(got), 32'(want));
      else if (exp_ptr >= 16) check("R10 status entry", 32'(got), 32'(want));
      else                    check("R5 R7 read data", 32'(got), 32'(want));
      if (exp_ptr == 12) exp_por = 1'b0;
      exp_ptr = nxt(exp_ptr);
    end
    check("R5 released after NACK", 32'(sda_oe), 0);
    bus_stop;
    wq();
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic a;
    void'($urandom(32'd4242));
    for (int i = 0; i < 16; i++) exp_mem[i] = dflt(i);
    exp_por = 1'b1;
    exp_ptr = 0;
    repeat (6) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);

    // R8: reset state
    check("R8 sda released", 32'(sda_oe), 0);
    chk_ctrl("R8 defaults");

    // R9 R10: status entries and power-on flag before 0x0C is read
    st_tf = 8'hA5; st_chip = 7'h3C; st_tune = 8'h5A;
    do_read(16, 3);

    // R1: foreign address is not acknowledged and its bytes are ignored
    bus_start;
    put_byte(8'hC2, a); check("R1 foreign nack", 32'(a), 0);
    put_byte(8'h00, a); check("R1 ignored byte", 32'(a), 0);
    put_byte(8'hEE, a); check("R1 ignored byte", 32'(a), 0);
    bus_stop; wq();
    chk_ctrl("R1 no write");

    // R1: pin high moves the address
    addr_sel = 1'b1;
    bus_start;
    put_byte(8'hC0, a); check("R1 old address nack", 32'(a), 0);
    bus_stop; wq();
    dbuf[0] = 8'h9E;
    do_write(2, 1);
    chk_ctrl("R1 R4 pin-high write");
    do_read(2, 1);
    addr_sel = 1'b0;

    // R6 R7: burst across read-only entries and the wrap
    for (int k = 0; k < 7; k++) dbuf[k] = 8'($urandom);
    do_write(14, 7);
    chk_ctrl("R6 R7 burst");
    do_read(17, 4);

    // R7: out-of-range pointer selects 0x00
    dbuf[0] = 8'h3D;
    do_write(64, 1);
    chk_ctrl("R7 pointer clamp");

    // R9: reading 0x0C clears the flag, writes to 0x11 do not restore it
    do_read(12, 1);
    do_read(17, 1);
    dbuf[0] = 8'hFF;
    do_write(17, 1);
    do_read(17, 1);

    // R2: STOP mid byte abandons it, STOP after address releases SDA
    bus_start;
    put_byte(dev(1'b0), a);
    put_byte(8'h05, a);
    put_bits(8'h00, 4);
    bus_stop; wq();
    check("R2 released after STOP", 32'(sda_oe), 0);
    chk_ctrl("R2 partial byte dropped");
    bus_start;
    put_byte(dev(1'b0), a); check("R2 R1 ack", 32'(a), 1);
    bus_stop; wq();
    check("R2 line high after STOP", 32'(sda_bus), 1);

    // R4 R5 R10: constrained random bursts
    for (int t = 0; t < 10; t++) begin
      int p, n;
      p = int'($urandom % 19);
      n = 1 + int'($urandom % 5);
      for (int k = 0; k < n; k++) dbuf[k] = 8'($urandom);
      do_write(p, n);
      chk_ctrl("R4 random write");
    end
    for (int t = 0; t < 10; t++) begin
      st_tf = 8'($urandom); st_chip = 7'($urandom); st_tune = 8'($urandom);
      do_read(int'($urandom % 19), 1 + int'($urandom % 4));
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule